// File: doc/BRIEF.md
# Synchronize-Controlled Time-Tag Counter

This block is the time-tag clock of a serial-bus remote terminal. It holds a 32-bit counter that advances by one on each pulse of a tick enable. The tick enable comes from an external prescaler. Command decoding lives elsewhere. That decoder hands the block one-cycle pulses for two synchronize mode commands: a plain synchronize, and a synchronize that carries a 16-bit data word.

A host-writable control word decides how the block reacts to each command. Bit 0 makes a plain synchronize clear the counter. Bit 1 makes a synchronize-with-data replace the low half with the received word, leaving the high half untouched. With a bit clear, the matching command is ignored.

The host reads the counter through a 16-bit port, as two words. Reading the high word captures the low half at that instant. The next low-word read then returns that captured value, so the two halves always belong to the same count.

Top module: `rtc_sync_timer`

## Requirements
- R1: Reset clears the counter, the captured low half, the pending-capture state and the control word; reads of every select then return 0.
- R2: On a cycle with `tickEn` high and no enabled synchronize action, the counter advances by exactly one, carrying from the low half into the high half and wrapping from all ones to zero. Without a tick or an action it holds its value.
- R3: Select 0 is the control word, a 16-bit read/write register. Bit 0 enables clear-on-synchronize and bit 1 enables load-on-synchronize-with-data; the other bits are stored and read back. Writes to selects 1, 2 and 3 change nothing, and select 3 reads as 0.
- R4: With control bit 0 set, a `syncPulse` makes the counter read 0 from the next cycle.
- R5: With control bit 1 set, a `syncDataPulse` loads `syncData` into counter bits 15:0 and leaves bits 31:16 unchanged.
- R6: A synchronize pulse whose control bit is clear has no effect; the counter behaves as if the pulse were absent, and a tick in that cycle still counts.
- R7: An enabled synchronize action beats a tick in the same cycle. A clear beats a load when both are enabled and pulse together.
- R8: A read of select 1 returns counter bits 31:16 as they stood in the read cycle and captures bits 15:0. The next read of select 2 returns the captured half and consumes it. A select-2 read with no capture pending returns the live bits 15:0.
- R9: Read data appears on `hostRdData` in the cycle after `hostRdEn` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaler tick, one-cycle pulse |
| syncPulse | input | 1 | Decoded plain synchronize command |
| syncDataPulse | input | 1 | Decoded synchronize-with-data command |
| syncData | input | 16 | Data word received with the synchronize-with-data command |
| hostRdEn | input | 1 | Host read strobe |
| hostWrEn | input | 1 | Host write strobe |
| hostSel | input | 2 | Register select: 0 control, 1 count high, 2 count low, 3 none |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Registered host read data |

## Verification
Every kind of corrupted internal state reaches the host port quickly:
- A wrong counter value shows up on the very next read of either half.
- A carry lost between the halves shows up only when the high word is read after the low half rolls over.
- A capture that is missing or stale gives a low-word read that disagrees with the count as it was at the preceding high-word read. This is visible one cycle after that low-word read.
- A wrong control word shows up the cycle after it is read back. It also shows up as a counter that fails to clear or load on the next synchronize pulse.

// File: rtl/rtc_sync_pkg.sv
`timescale 1ns/1ps
package rtc_sync_pkg;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HIGH = 2'd1;
  localparam logic [1:0] SEL_LOW  = 2'd2;
  localparam int ZERO_BIT = 0;
  localparam int LOAD_BIT = 1;

  typedef struct packed {
    logic       zeroCnt;
    logic       loadLow;
    logic       incr;
    logic       takeSnap;
    logic       useSnap;
    logic       rdEn;
    logic [1:0] rdSel;
  } rtcStrobes_t;
endpackage

// File: rtl/rtc_sync_ctrl.sv
`timescale 1ns/1ps
module rtc_sync_ctrl
  import rtc_sync_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              syncPulse,
  input  logic              syncDataPulse,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] ctrlQ,
  output rtcStrobes_t       strb
);
  logic snapPend;
  logic zeroHit;
  logic loadHit;

  always_comb begin
    zeroHit       = syncPulse & ctrlQ[ZERO_BIT];
    loadHit       = syncDataPulse & ctrlQ[LOAD_BIT] & ~zeroHit;
    strb.zeroCnt  = zeroHit;
    strb.loadLow  = loadHit;
    strb.incr     = tickEn & ~zeroHit & ~loadHit;
    strb.takeSnap = hostRdEn & (hostSel == SEL_HIGH);
    strb.useSnap  = hostRdEn & (hostSel == SEL_LOW) & snapPend;
    strb.rdEn     = hostRdEn;
    strb.rdSel    = hostSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      snapPend <= 1'b0;
    end else begin
      if (hostWrEn && hostSel == SEL_CTRL) ctrlQ <= hostWrData;
      if (strb.takeSnap)                          snapPend <= 1'b1;
      else if (hostRdEn && hostSel == SEL_LOW)    snapPend <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sync_dp.sv
`timescale 1ns/1ps
module rtc_sync_dp
  import rtc_sync_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtcStrobes_t       strb,
  input  logic [WORD_W-1:0] syncData,
  input  logic [WORD_W-1:0] ctrlQ,
  output logic [2*WORD_W-1:0] countQ,
  output logic [WORD_W-1:0] hostRdData
);
  localparam int CNT_W = 2 * WORD_W;

  logic [WORD_W-1:0] snapLow;
  logic [WORD_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              countQ <= '0;
    else if (strb.zeroCnt)  countQ <= '0;
    else if (strb.loadLow)  countQ <= {countQ[CNT_W-1:WORD_W], syncData};
    else if (strb.incr)     countQ <= countQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              snapLow <= '0;
    else if (strb.takeSnap) snapLow <= countQ[WORD_W-1:0];
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL: rdNext = ctrlQ;
      SEL_HIGH: rdNext = countQ[CNT_W-1:WORD_W];
      SEL_LOW:  rdNext = strb.useSnap ? snapLow : countQ[WORD_W-1:0];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hostRdData <= '0;
    else if (strb.rdEn) hostRdData <= rdNext;
  end
endmodule

// File: rtl/rtc_sync_timer.sv
`timescale 1ns/1ps
module rtc_sync_timer
  import rtc_sync_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              syncPulse,
  input  logic              syncDataPulse,
  input  logic [WORD_W-1:0] syncData,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData
);
  rtcStrobes_t         strb;
  logic [WORD_W-1:0]   ctrlQ;
  logic [2*WORD_W-1:0] countQ;

  rtc_sync_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .syncPulse(syncPulse),
    .syncDataPulse(syncDataPulse), .hostRdEn(hostRdEn), .hostWrEn(hostWrEn),
    .hostSel(hostSel), .hostWrData(hostWrData), .ctrlQ(ctrlQ), .strb(strb)
  );

  rtc_sync_dp #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .syncData(syncData), .ctrlQ(ctrlQ),
    .countQ(countQ), .hostRdData(hostRdData)
  );
endmodule

// File: rtl/rtc_sync_checker.sv
`timescale 1ns/1ps
module rtc_sync_checker #(
  parameter int WORD_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                tickEn,
  input logic                syncPulse,
  input logic                syncDataPulse,
  input logic [WORD_W-1:0]   syncData,
  input logic                hostRdEn,
  input logic                hostWrEn,
  input logic [1:0]          hostSel,
  input logic [WORD_W-1:0]   hostWrData,
  input logic [WORD_W-1:0]   ctrlQ,
  input logic [2*WORD_W-1:0] countQ,
  input logic [WORD_W-1:0]   hostRdData
);
  localparam int CNT_W = 2 * WORD_W;
  logic zeroAct;
  logic loadAct;
  assign zeroAct = syncPulse & ctrlQ[0];
  assign loadAct = syncDataPulse & ctrlQ[1];

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (countQ == '0 && ctrlQ == '0 && hostRdData == '0));

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !zeroAct && !loadAct) |=> countQ == $past(countQ) + CNT_W'(1));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !zeroAct && !loadAct) |=> $stable(countQ));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostSel == 2'd0) |=> ctrlQ == $past(hostWrData));

  assert_sync_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    zeroAct |=> countQ == '0);

  assert_sync_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadAct && !zeroAct) |=>
      countQ == {$past(countQ[CNT_W-1:WORD_W]), $past(syncData)});

  assert_read_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostSel == 2'd1) |=> hostRdData == $past(countQ[CNT_W-1:WORD_W]));

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !hostRdEn |=> $stable(hostRdData));
endmodule

bind rtc_sync_timer rtc_sync_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .syncPulse(syncPulse),
  .syncDataPulse(syncDataPulse), .syncData(syncData), .hostRdEn(hostRdEn),
  .hostWrEn(hostWrEn), .hostSel(hostSel), .hostWrData(hostWrData),
  .ctrlQ(ctrlQ), .countQ(countQ), .hostRdData(hostRdData)
);

// File: tb/rtc_sync_timer_tb.sv
`timescale 1ns/1ps
module rtc_sync_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, syncPulse = 1'b0, syncDataPulse = 1'b0;
  logic [15:0] syncData = '0;
  logic        hostRdEn = 1'b0, hostWrEn = 1'b0;
  logic [1:0]  hostSel = '0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;

  typedef struct {
    int          due;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  int cycleCnt = 0, checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mCount = '0;
  logic [15:0] mCtrl = '0, mSnap = '0, mLast = '0;
  bit mPend = 0;

  always #2.5 clk = ~clk;

  rtc_sync_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .syncPulse(syncPulse),
    .syncDataPulse(syncDataPulse), .syncData(syncData), .hostRdEn(hostRdEn),
    .hostWrEn(hostWrEn), .hostSel(hostSel), .hostWrData(hostWrData),
    .hostRdData(hostRdData)
  );

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // monitor: compares results when they fall due
  always @(negedge clk) begin
    item_t it;
    while (expQ.size() > 0 && expQ[0].due <= cycleCnt) begin
      it = expQ.pop_front();
      checks++;
      if (hostRdData !== it.exp) begin
        fails++;
        $display("FAIL %s: hostRdData=%h expected %h", it.tag, hostRdData, it.exp);
      end
    end
  end

  // driver: one cycle of stimulus, expected value pushed, model advanced
  task automatic step(input bit tk, input bit sy, input bit sd, input logic [15:0] dat,
                      input bit rd, input logic [1:0] sel, input bit wr,
                      input logic [15:0] wdat, input string tag);
    logic [15:0] e;
    @(negedge clk);
    tickEn = tk; syncPulse = sy; syncDataPulse = sd; syncData = dat;
    hostRdEn = rd; hostSel = sel; hostWrEn = wr; hostWrData = wdat;
    if (rd) begin
      case (sel)
        2'd0: e = mCtrl;
        2'd1: e = mCount[31:16];
        2'd2: e = mPend ? mSnap : mCount[15:0];
        default: e = 16'h0;
      endcase
      mLast = e;
      expQ.push_back('{cycleCnt + 1, e, tag});
      if (sel == 2'd1) begin mSnap = mCount[15:0]; mPend = 1; end
      if (sel == 2'd2) mPend = 0;
    end
    if (sy && mCtrl[0])      mCount = '0;
    else if (sd && mCtrl[1]) mCount = {mCount[31:16], dat};
    else if (tk)             mCount = mCount + 32'd1;
    if (wr && sel == 2'd0) mCtrl = wdat;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, 2'd0, 0, '0, "");
  endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1, 0, 0, '0, 0, 2'd0, 0, '0, "");
  endtask
  task automatic rdReg(input logic [1:0] sel, input string tag);
    step(0, 0, 0, '0, 1, sel, 0, '0, tag);
  endtask
  task automatic wrReg(input logic [1:0] sel, input logic [15:0] v);
    step(0, 0, 0, '0, 0, sel, 1, v, "");
  endtask
  task automatic holdCheck(input string tag);
    @(negedge clk);
    expQ.push_back('{cycleCnt + 1, mLast, tag});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdReg(2'd0, "R1 ctrl"); rdReg(2'd1, "R1 high"); rdReg(2'd2, "R1 low");
    // R2 counting and carry
    tick(5); rdReg(2'd1, "R2 high"); rdReg(2'd2, "R2 low");
    wrReg(2'd0, 16'h0002);
    step(0, 0, 1, 16'hFFFE, 0, 2'd0, 0, '0, "");
    wrReg(2'd0, 16'h0000);
    tick(3); rdReg(2'd1, "R2 carry high"); rdReg(2'd2, "R2 carry low");
    // R9 hold without read
    idle(2); holdCheck("R9 hold"); idle(2);
    // R6 disabled options
    step(1, 1, 0, '0, 0, 2'd0, 0, '0, "");
    step(0, 0, 1, 16'h5555, 0, 2'd0, 0, '0, "");
    rdReg(2'd1, "R6 high"); rdReg(2'd2, "R6 low");
    // R4 clear on sync
    wrReg(2'd0, 16'h0001); tick(4);
    step(0, 1, 0, '0, 0, 2'd0, 0, '0, "");
    rdReg(2'd1, "R4 high"); rdReg(2'd2, "R4 low");
    // R7 sync beats tick, clear beats load
    tick(2); step(1, 1, 0, '0, 0, 2'd0, 0, '0, "");
    rdReg(2'd2, "R7 sync vs tick");
    wrReg(2'd0, 16'h0003); tick(2);
    step(0, 1, 1, 16'h1234, 0, 2'd0, 0, '0, "");
    rdReg(2'd2, "R7 clear vs load");
    // R5 load low keeps high
    wrReg(2'd0, 16'h0002);
    step(0, 0, 1, 16'hFFFF, 0, 2'd0, 0, '0, "");
    tick(1);
    step(1, 0, 1, 16'hABCD, 0, 2'd0, 0, '0, "");
    rdReg(2'd1, "R5 high"); rdReg(2'd2, "R5 low");
    // R8 coherent pair
    rdReg(2'd1, "R8 high"); tick(3);
    rdReg(2'd2, "R8 captured low"); rdReg(2'd2, "R8 live low");
    step(1, 0, 0, '0, 1, 2'd1, 0, '0, "R8 high with tick");
    rdReg(2'd2, "R8 low after tick");
    // R3 control register and ignored writes
    wrReg(2'd0, 16'hA5A4); rdReg(2'd0, "R3 ctrl readback");
    wrReg(2'd1, 16'h1234); wrReg(2'd2, 16'h4321); wrReg(2'd3, 16'hFFFF);
    rdReg(2'd1, "R3 high unchanged"); rdReg(2'd2, "R3 low unchanged");
    rdReg(2'd3, "R3 sel3 zero"); rdReg(2'd0, "R3 ctrl unchanged");
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expected end of test, got timeout");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule